// File: doc/BRIEF.md
# Eight-Pin I/O Port with Per-Nibble Input Filtering

This block is one byte-wide general-purpose I/O port. Software reaches it through a small register window: a 3-bit offset, a one-cycle write strobe, and a read path that is combinational from the offset. Each pin's output level and output enable are held in registers and passed to the pad. A pull-up request per pin is passed to the pad in the same way. The pad levels come back through a two-flop synchronizer and a filter stage, and then reach the readable input byte.

The pins form two groups of four: a low group (pins 3:0) and a high group (pins 7:4). Each group has its own 3-bit filter setting. A setting of zero passes the synchronized level straight through. Any other setting makes a pin wait until its synchronized input has differed from its accepted level for a whole settle window. The window is a power of two, in clock cycles, and it doubles with each step of the setting. A pin that returns to its accepted level before the window ends loses the count it has built up. Changing a group's setting also clears that group's counts. The Schmitt trigger control is shown only as a read-only byte that always reads all ones.

Top module: `gpio_filt_port`

## Requirements
- R1: After reset the registers read as follows: output data (offset 1) 0x00, output enable (offset 2) 0x00, pull-up (offset 3) 0xFF, input enable (offset 4) 0xFF, filter control (offset 5) 0x00.
- R2: A write with `wrEn` high at offsets 1 to 4 stores `wrData` at that clock edge. A later read at the same offset returns the stored byte with no clock in between.
- R3: `padOe` equals the output enable register. `padOut[i]` equals output data bit i when `padOe[i]` is 1, and is 0 otherwise.
- R4: `padPullUp` equals the pull-up register, where 1 requests the pull-up.
- R5: The input byte (offset 0) returns the filtered level of pin i in bit i (1 for high) when input enable bit i is 1. It returns 0 in that bit when the enable bit is 0.
- R6: When a group's filter setting is 0, a pad level that is applied before clock edge k shows in the input byte after edge k+2 and not before.
- R7: Filter control bits 2:0 set the low group and bits 6:4 set the high group. A setting s from 1 to 7 gives a window W of 2^(SHIFT_BASE+s-1) cycles. A held level change applied before edge k is accepted after edge k+1+W and not earlier.
- R8: If the input returns to the accepted level after being different for fewer than W cycles, the pin keeps its level. A later change needs a full new window.
- R9: A write to offset 5 that changes a group's setting clears that group's counts at that edge. A pending change is then accepted W_new cycles after the write edge.
- R10: Bits 3 and 7 of the filter control always read 0. Writes to offsets 0, 6 and 7 change nothing. Offset 6 always reads 0xFF and offset 7 always reads 0x00.
- R11: A change on the pins of one group does not alter the filtered levels of the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | One-cycle register write strobe |
| addr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| padIn | input | 8 | Raw pad input levels |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output drive enables |
| padPullUp | output | 8 | Pad pull-up requests |

## Verification
A counter that starts from the wrong value, or that misses a clear, makes a filtered bit flip at the wrong edge. This shows in the input byte within one settle window, so the bench reads that byte exactly one cycle before and one cycle after the expected edge. A setting that does not clear the counts shows as an edge placed against the old window. A setting decoded from the wrong bits moves the timing of the other group. The output-side registers show at the pad pins in the same cycle as the write edge.

// File: rtl/gpio_filt_pkg.sv
package gpio_filt_pkg;
  localparam int PORT_W = 8;
  localparam int NGRP   = 2;
  localparam int GRP_W  = PORT_W / NGRP;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_IN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT = 3'd1;
  localparam logic [ADDR_W-1:0] A_OE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PU  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DEB = 3'd5;
  localparam logic [ADDR_W-1:0] A_SMT = 3'd6;

  typedef struct packed {
    logic            outWr;
    logic            oeWr;
    logic            puWr;
    logic            ieWr;
    logic [NGRP-1:0] restart;
  } strobe_t;
endpackage

// File: rtl/gpio_filt_ctrl.sv
module gpio_filt_ctrl
  import gpio_filt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NGRP-1:0][SEL_W-1:0] newSel,
  output strobe_t                    strobe,
  output logic [NGRP-1:0][SEL_W-1:0] selCfg
);
  logic debWr;

  // decode the write strobe for each writable register
  always_comb begin
    debWr         = wrEn && (addr == A_DEB);
    strobe.outWr  = wrEn && (addr == A_OUT);
    strobe.oeWr   = wrEn && (addr == A_OE);
    strobe.puWr   = wrEn && (addr == A_PU);
    strobe.ieWr   = wrEn && (addr == A_IE);
    for (int g = 0; g < NGRP; g++) begin
      strobe.restart[g] = debWr && (newSel[g] != selCfg[g]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCfg <= '0;
    end else if (debWr) begin
      selCfg <= newSel;
    end
  end
endmodule

// File: rtl/gpio_filt_deb.sv
module gpio_filt_deb
  import gpio_filt_pkg::*;
#(
  parameter int SHIFT_BASE = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic [GRP_W-1:0] syncIn,
  output logic [GRP_W-1:0] debOut
);
  localparam int CNT_W = SHIFT_BASE + (1 << SEL_W) - 2;

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;

  // terminal count for the selected window: 2^(base+sel-1) - 1
  always_comb begin
    span = (CNT_W+1)'(1) << (SHIFT_BASE - 1 + int'(sel));
    lim  = CNT_W'(span - (CNT_W+1)'(1));
  end

  for (genvar i = 0; i < GRP_W; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt       <= '0;
        debOut[i] <= 1'b0;
      end else if (restart) begin
        cnt <= '0;
      end else if (sel == '0) begin
        cnt       <= '0;
        debOut[i] <= syncIn[i];
      end else if (syncIn[i] == debOut[i]) begin
        cnt <= '0;
      end else if (cnt == lim) begin
        cnt       <= '0;
        debOut[i] <= syncIn[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_filt_data.sv
module gpio_filt_data
  import gpio_filt_pkg::*;
#(
  parameter int SHIFT_BASE = 8
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [NGRP-1:0][SEL_W-1:0] selCfg,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [PORT_W-1:0]          wrData,
  input  logic [PORT_W-1:0]          padIn,
  output logic [PORT_W-1:0]          rdData,
  output logic [PORT_W-1:0]          padOut,
  output logic [PORT_W-1:0]          padOe,
  output logic [PORT_W-1:0]          padPullUp,
  output logic [PORT_W-1:0]          syncVal,
  output logic [PORT_W-1:0]          debVal
);
  logic [PORT_W-1:0] outReg, oeReg, puReg, ieReg, meta, debRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      oeReg   <= '0;
      puReg   <= '1;
      ieReg   <= '1;
      meta    <= '0;
      syncVal <= '0;
    end else begin
      meta    <= padIn;
      syncVal <= meta;
      if (strobe.outWr) outReg <= wrData;
      if (strobe.oeWr)  oeReg  <= wrData;
      if (strobe.puWr)  puReg  <= wrData;
      if (strobe.ieWr)  ieReg  <= wrData;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio_filt_deb #(.SHIFT_BASE(SHIFT_BASE)) i_deb (
      .clk     (clk),
      .rstN    (rstN),
      .sel     (selCfg[g]),
      .restart (strobe.restart[g]),
      .syncIn  (syncVal[g*GRP_W +: GRP_W]),
      .debOut  (debVal[g*GRP_W +: GRP_W])
    );
  end

  always_comb begin
    debRd = '0;
    for (int g = 0; g < NGRP; g++) begin
      debRd[g*GRP_W +: SEL_W] = selCfg[g];
    end
  end

  assign padOe     = oeReg;
  assign padOut    = outReg & oeReg;
  assign padPullUp = puReg;

  always_comb begin
    unique case (addr)
      A_IN:    rdData = debVal & ieReg;
      A_OUT:   rdData = outReg;
      A_OE:    rdData = oeReg;
      A_PU:    rdData = puReg;
      A_IE:    rdData = ieReg;
      A_DEB:   rdData = debRd;
      A_SMT:   rdData = '1;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_filt_port.sv
module gpio_filt_port
  import gpio_filt_pkg::*;
#(
  parameter int SHIFT_BASE = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        padIn,
  output logic [7:0]        padOut,
  output logic [7:0]        padOe,
  output logic [7:0]        padPullUp
);
  strobe_t                    strobe;
  logic [NGRP-1:0][SEL_W-1:0] newSel, selCfg;
  logic [PORT_W-1:0]          syncVal, debVal;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      newSel[g] = wrData[g*GRP_W +: SEL_W];
    end
  end

  gpio_filt_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .newSel (newSel),
    .strobe (strobe),
    .selCfg (selCfg)
  );

  gpio_filt_data #(.SHIFT_BASE(SHIFT_BASE)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .selCfg    (selCfg),
    .addr      (addr),
    .wrData    (wrData),
    .padIn     (padIn),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp),
    .syncVal   (syncVal),
    .debVal    (debVal)
  );
endmodule

// File: rtl/gpio_filt_chk.sv
module gpio_filt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] addr,
  input logic [7:0] rdData,
  input logic [7:0] padOut,
  input logic [7:0] padOe,
  input logic [7:0] padPullUp,
  input logic [7:0] syncVal,
  input logic [7:0] debVal
);
  // R2: drive enables move only on a write to their offset
  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd2) |=> $stable(padOe));

  // R4: pull-up requests move only on a write to their offset
  p_pu_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd3) |=> $stable(padPullUp));

  // R3: an undriven pin never shows a high output level
  p_pad_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == 8'h00);

  // R10: reserved control bits and the fixed bytes
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd5) |-> (rdData[3] == 1'b0 && rdData[7] == 1'b0));

  p_schmitt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd6) |-> (rdData == 8'hFF));

  // R7: a filtered bit can only change toward the synchronized level
  p_deb_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((debVal ^ $past(debVal)) & (debVal ^ $past(syncVal))) == 8'h00));
endmodule

bind gpio_filt_port gpio_filt_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .rdData    (rdData),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullUp (padPullUp),
  .syncVal   (syncVal),
  .debVal    (debVal)
);

// File: tb/test_gpio_filt_port.sv
`timescale 1ns/1ps
module test_gpio_filt_port;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] pad = 8'h00;
  logic [7:0] padOut, padOe, padPullUp;
  int nChk = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  gpio_filt_port #(.SHIFT_BASE(BASE)) i_gpio_filt_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(pad), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #0.5;
    chk(req, rdData, exp);
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int windowOf(input int s);
    return (s == 0) ? 1 : (1 << (BASE + s - 1));
  endfunction

  // apply a new level on a group and check the accept edge
  task automatic transition(input int g, input int s, input logic lvl, input string req);
    logic [7:0] oldPad, mask;
    int w;
    w = windowOf(s);
    mask = 8'h0F << (4 * g);
    oldPad = pad;
    @(negedge clk);
    pad = lvl ? (pad | mask) : (pad & ~mask);
    steps(1 + w);
    rdChk(3'd0, oldPad, {req, " before window"});
    steps(1);
    rdChk(3'd0, pad, {req, " after window"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    steps(2);
    rstN = 1'b1;
    steps(1);
    // R1 reset values
    rdChk(3'd1, 8'h00, "R1 out");
    rdChk(3'd2, 8'h00, "R1 oe");
    rdChk(3'd3, 8'hFF, "R1 pu");
    rdChk(3'd4, 8'hFF, "R1 ie");
    rdChk(3'd5, 8'h00, "R1 filter");
    chk("R4 reset pull", padPullUp, 8'hFF);
    chk("R3 reset oe", padOe, 8'h00);

    // R2 / R3 sweep of enables against a fixed output byte
    @(negedge clk);
    wr(3'd1, 8'hA5);
    rdChk(3'd1, 8'hA5, "R2 out readback");
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      #0.5;
      chk("R3 padOe", padOe, 8'(v));
      chk("R3 padOut", padOut, 8'hA5 & 8'(v));
      rdChk(3'd2, 8'(v), "R2 oe readback");
    end
    wr(3'd3, 8'h3C);
    #0.5;
    chk("R4 pull", padPullUp, 8'h3C);
    rdChk(3'd3, 8'h3C, "R2 pu readback");

    // R6 bypass latency over every pad byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = pad;
      @(negedge clk);
      pad = 8'(v);
      steps(2);
      rdChk(3'd0, prev, "R6 before latency");
      steps(1);
      rdChk(3'd0, 8'(v), "R6 after latency");
    end

    // R5 input enable masking
    @(negedge clk);
    pad = 8'h5A;
    steps(4);
    for (int m = 0; m < 16; m++) begin
      logic [7:0] ie;
      ie = 8'(m * 17) ^ 8'h96;
      wr(3'd4, ie);
      rdChk(3'd0, 8'h5A & ie, "R5 masked input");
    end
    wr(3'd4, 8'hFF);
    @(negedge clk);
    pad = 8'h00;
    steps(4);

    // R7 / R11 sweep all settings on each group
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        wr(3'd5, 8'(s << (4 * g)));
        rdChk(3'd5, 8'(s << (4 * g)), "R7 field position");
        transition(g, s, 1'b1, g ? "R7 R11 hi rise" : "R7 R11 lo rise");
        transition(g, s, 1'b0, g ? "R7 R11 hi fall" : "R7 R11 lo fall");
      end
    end

    // R8 glitch shorter than the window is dropped
    @(negedge clk);
    wr(3'd5, 8'h02);
    @(negedge clk);
    pad = 8'h0F;
    steps(windowOf(2) - 1);
    pad = 8'h00;
    steps(20);
    rdChk(3'd0, 8'h00, "R8 short pulse ignored");
    transition(0, 2, 1'b1, "R8 full window after glitch");

    // R9 setting change restarts the count
    @(negedge clk);
    wr(3'd5, 8'h00);
    pad = 8'h00;
    steps(4);
    wr(3'd5, 8'h03);
    @(negedge clk);
    pad = 8'h0F;
    steps(8);
    wr(3'd5, 8'h01);
    steps(windowOf(1) - 1);
    rdChk(3'd0, 8'h00, "R9 before new window");
    steps(1);
    rdChk(3'd0, 8'h0F, "R9 after new window");

    // R10 reserved bits and read-only offsets
    @(negedge clk);
    wr(3'd5, 8'hFF);
    rdChk(3'd5, 8'h77, "R10 reserved bits");
    wr(3'd5, 8'h00);
    steps(4);
    wr(3'd0, 8'h00);
    rdChk(3'd0, 8'h0F, "R10 input not writable");
    wr(3'd6, 8'h00);
    rdChk(3'd6, 8'hFF, "R10 schmitt byte");
    wr(3'd7, 8'hFF);
    rdChk(3'd7, 8'h00, "R10 spare offset");
    rdChk(3'd1, 8'hA5, "R10 out untouched");
    rdChk(3'd2, 8'hFF, "R10 oe untouched");
    rdChk(3'd3, 8'h3C, "R10 pu untouched");
    rdChk(3'd4, 8'hFF, "R10 ie untouched");

    $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule